// File: doc/BRIEF.md
# Configuration Unlock Key Detector

This block watches byte writes to a configuration address port and opens the card's configuration logic only after software has written one of two fixed 32-byte unlock sequences, each byte in order and with no error. One sequence is the standard one, built from an 8-bit shift-register pattern. The other is an alternate vendor sequence, built from a simple arithmetic rule. A two-bit mode strap sets which sequences count. The alternate sequence opens the logic in every mode. The standard sequence opens it only when the strap selects the plug-and-play mode.

Each sequence has its own position counter, and both counters advance in parallel on every strobed write. A wrong byte sends a counter back to the start, so the whole sequence has to be written again. When a sequence completes, the sticky `cfg_en` output goes high. It stays high until reset or until the exit command clears it.

Top module: `pnp_initkey_detector`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cfg_en` is 0. A reset in the middle of a sequence drops all progress, so the bytes that follow the reset cannot complete the sequence that was under way.
- R2: Only cycles with `wr_stb` high count as writes. Idle cycles between written bytes neither advance nor reset the match progress.
- R3: A written byte that does not equal the next expected byte of a sequence, and is not that sequence's first byte, returns the sequence to its start. Bytes written after such an error cannot complete it; only a full new sequence can.
- R4: The standard sequence is 32 bytes long. Its byte 0 is 0x6A. Each next byte is the current byte shifted right by one, with bit 7 set to bit 1 XOR bit 0 of the current byte. When the 32nd byte is taken at a clock edge while `cfg_mode` = 2'b10, `cfg_en` is 1 from that edge on.
- R5: The alternate sequence is 32 bytes long, with byte k = (37*k + 0x5C) mod 256. Completing it sets `cfg_en` at the edge that takes byte 31, whatever the value of `cfg_mode`.
- R6: With `cfg_mode` at 2'b00, 2'b01 or 2'b11, a complete standard sequence leaves `cfg_en` at 0.
- R7: A wrong byte that equals the first byte of a sequence counts as that sequence's byte 0. After it, bytes 1 to 31 complete the sequence.
- R8: `cfg_en` stays 1 until reset, or until `exit_cmd` is high at a clock edge, which clears it. If `exit_cmd` comes at the same edge that completes a sequence, the exit wins and `cfg_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Write strobe for the address port |
| wr_data | input | 8 | Byte written to the address port |
| cfg_mode | input | 2 | Mode strap: 00 jumper, 01 jumperless, 10 plug-and-play, 11 reserved |
| exit_cmd | input | 1 | Exit-configuration command, clears the enable |
| cfg_en | output | 1 | Sticky configuration enable |

## Verification
The assertions check several things on every cycle. Both match positions hold still through idle cycles. A position only ever steps up by one or falls back to zero or one. `cfg_en` rises only after a write that completes a sequence, and only through the alternate counter when the strap is not plug-and-play. `cfg_en` holds until an exit and drops after one. The bench scenarios show what the assertions cannot. These are the actual byte values of both sequences, the restart behaviour after a wrong byte and after a repeated first byte, the exit winning over a completion in the same cycle, and progress being lost across a mid-sequence reset.

// File: rtl/pnp_key_pkg.sv
package pnp_key_pkg;

   typedef logic [7:0] key_byte_t;

   typedef enum logic {
      KEY_LFSR  = 1'b0,
      KEY_TABLE = 1'b1
   } key_kind_e;

   // Byte idx of the shift-register sequence started at seed.
   function automatic key_byte_t lfsr_key_byte(input key_byte_t seed, input int idx);
      key_byte_t v;
      v = seed;
      for (int i = 0; i < 256; i++) begin
         if (i < idx) v = {v[1] ^ v[0], v[7:1]};
      end
      return v;
   endfunction

   // Byte idx of the arithmetic table sequence.
   function automatic key_byte_t table_key_byte(input int mul, input key_byte_t ofs, input int idx);
      logic [15:0] p;
      p = 16'(idx) * 16'(mul) + 16'(ofs);
      return p[7:0];
   endfunction

endpackage

// File: rtl/pnp_key_rom.sv
module pnp_key_rom
   import pnp_key_pkg::*;
#(
   parameter int        KEY_LEN  = 32,
   parameter key_kind_e KIND     = KEY_LFSR,
   parameter key_byte_t SEED     = 8'h6A,
   parameter int        TBL_MUL  = 37,
   parameter key_byte_t TBL_OFS  = 8'h5C,
   localparam int       IDX_W    = $clog2(KEY_LEN)
) (
   input  logic [IDX_W-1:0] idx,
   output key_byte_t        byte_o,
   output key_byte_t        first_o
);

   key_byte_t rom [KEY_LEN];

   generate
      if (KIND == KEY_LFSR) begin : g_lfsr
         for (genvar i = 0; i < KEY_LEN; i++) begin : g_ent
            assign rom[i] = lfsr_key_byte(SEED, i);
         end
      end else begin : g_table
         for (genvar i = 0; i < KEY_LEN; i++) begin : g_ent
            assign rom[i] = table_key_byte(TBL_MUL, TBL_OFS, i);
         end
      end
   endgenerate

   assign byte_o  = rom[idx];
   assign first_o = rom[0];

endmodule

// File: rtl/pnp_key_matcher.sv
module pnp_key_matcher
   import pnp_key_pkg::*;
#(
   parameter int        KEY_LEN = 32,
   parameter key_kind_e KIND    = KEY_LFSR,
   parameter key_byte_t SEED    = 8'h6A,
   parameter int        TBL_MUL = 37,
   parameter key_byte_t TBL_OFS = 8'h5C,
   localparam int       IDX_W   = $clog2(KEY_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  key_byte_t        wr_data,
   output logic             hit,
   output logic [IDX_W-1:0] pos
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(KEY_LEN - 1);

   key_byte_t        exp_byte;
   key_byte_t        first_byte;
   logic [IDX_W-1:0] pos_nxt;

   pnp_key_rom #(
      .KEY_LEN (KEY_LEN),
      .KIND    (KIND),
      .SEED    (SEED),
      .TBL_MUL (TBL_MUL),
      .TBL_OFS (TBL_OFS)
   ) u_rom (
      .idx     (pos),
      .byte_o  (exp_byte),
      .first_o (first_byte)
   );

   always_comb begin
      pos_nxt = pos;
      hit     = 1'b0;
      if (wr_stb) begin
         if (wr_data == exp_byte) begin
            if (pos == LAST) begin
               hit     = 1'b1;
               pos_nxt = '0;
            end else begin
               pos_nxt = pos + 1'b1;
            end
         end else if (wr_data == first_byte) begin
            pos_nxt = IDX_W'(1);
         end else begin
            pos_nxt = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos <= '0;
      else        pos <= pos_nxt;
   end

endmodule

// File: rtl/pnp_initkey_detector.sv
module pnp_initkey_detector
   import pnp_key_pkg::*;
#(
   parameter int          KEY_LEN   = 32,
   parameter key_byte_t   STD_SEED  = 8'h6A,
   parameter int          ALT_MUL   = 37,
   parameter key_byte_t   ALT_OFS   = 8'h5C,
   parameter logic [1:0]  PNP_MODE  = 2'b10,
   localparam int         IDX_W     = $clog2(KEY_LEN),
   localparam int         N_KEYS    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_stb,
   input  logic [7:0] wr_data,
   input  logic [1:0] cfg_mode,
   input  logic       exit_cmd,
   output logic       cfg_en
);

   if (KEY_LEN < 2 || (1 << IDX_W) != KEY_LEN) begin : g_bad_len
      $error("KEY_LEN must be a power of two of at least 2");
   end
   if (ALT_MUL % 2 == 0) begin : g_bad_mul
      $error("ALT_MUL must be odd so table bytes stay distinct");
   end

   logic [N_KEYS-1:0] key_hit;
   logic [IDX_W-1:0]  key_pos [N_KEYS];
   logic [IDX_W-1:0]  std_pos;
   logic [IDX_W-1:0]  alt_pos;
   logic              std_ok;
   logic              alt_ok;

   // Index 0 carries the standard sequence, index 1 the alternate one.
   for (genvar k = 0; k < N_KEYS; k++) begin : g_key
      pnp_key_matcher #(
         .KEY_LEN (KEY_LEN),
         .KIND    (k == 0 ? KEY_LFSR : KEY_TABLE),
         .SEED    (STD_SEED),
         .TBL_MUL (ALT_MUL),
         .TBL_OFS (ALT_OFS)
      ) u_match (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_stb  (wr_stb),
         .wr_data (wr_data),
         .hit     (key_hit[k]),
         .pos     (key_pos[k])
      );
   end

   assign std_pos = key_pos[0];
   assign alt_pos = key_pos[1];
   assign std_ok  = key_hit[0] && (cfg_mode == PNP_MODE);
   assign alt_ok  = key_hit[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cfg_en <= 1'b0;
      else if (exit_cmd)         cfg_en <= 1'b0;
      else if (std_ok || alt_ok) cfg_en <= 1'b1;
   end

endmodule

// File: rtl/pnp_initkey_detector_chk.sv
module pnp_initkey_detector_chk #(
   parameter int         KEY_LEN  = 32,
   parameter logic [1:0] PNP_MODE = 2'b10,
   localparam int        IDX_W    = $clog2(KEY_LEN)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_stb,
   input logic [1:0]       cfg_mode,
   input logic             exit_cmd,
   input logic             cfg_en,
   input logic [IDX_W-1:0] std_pos,
   input logic [IDX_W-1:0] alt_pos
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(KEY_LEN - 1);

   assert_exit_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exit_cmd |=> !cfg_en);

   assert_en_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && !exit_cmd) |=> cfg_en);

   assert_rise_needs_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_en) |-> ($past(wr_stb) &&
         ($past(alt_pos) == LAST ||
          ($past(std_pos) == LAST && $past(cfg_mode) == PNP_MODE))));

   assert_mode_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cfg_en) && $past(cfg_mode) != PNP_MODE) |-> ($past(alt_pos) == LAST));

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> ($stable(std_pos) && $stable(alt_pos)));

   assert_std_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (std_pos <= IDX_W'(1) || std_pos == $past(std_pos) + 1'b1));

   assert_alt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (alt_pos <= IDX_W'(1) || alt_pos == $past(alt_pos) + 1'b1));

endmodule

bind pnp_initkey_detector pnp_initkey_detector_chk #(
   .KEY_LEN  (KEY_LEN),
   .PNP_MODE (PNP_MODE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_stb   (wr_stb),
   .cfg_mode (cfg_mode),
   .exit_cmd (exit_cmd),
   .cfg_en   (cfg_en),
   .std_pos  (std_pos),
   .alt_pos  (alt_pos)
);

// File: tb/pnp_initkey_detector_test.sv
`timescale 1ns/1ps
module pnp_initkey_detector_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [1:0] cfg_mode = 2'b00;
   logic       exit_cmd = 1'b0;
   logic       cfg_en;

   int    n_vec = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   logic [7:0] std_k [32];
   logic [7:0] alt_k [32];

   // reference model state
   int m_std = 0;
   int m_alt = 0;
   bit m_en  = 1'b0;

   always #4 clk = ~clk;

   pnp_initkey_detector uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_stb),
      .wr_data  (wr_data),
      .cfg_mode (cfg_mode),
      .exit_cmd (exit_cmd),
      .cfg_en   (cfg_en)
   );

   initial begin
      logic [7:0] v;
      v = 8'h6A;
      for (int i = 0; i < 32; i++) begin
         std_k[i] = v;
         v = {v[1] ^ v[0], v[7:1]};
         alt_k[i] = 8'((37 * i + 92) % 256);
      end
   end

   function automatic int step(int p, logic [7:0] d, logic [7:0] e, logic [7:0] f);
      if (d == e) return p + 1;
      if (d == f) return 1;
      return 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_std <= 0;
         m_alt <= 0;
         m_en  <= 1'b0;
      end else begin
         int ns, na;
         bit fin;
         ns = m_std;
         na = m_alt;
         fin = 1'b0;
         if (wr_stb) begin
            ns = step(m_std, wr_data, std_k[m_std], std_k[0]);
            na = step(m_alt, wr_data, alt_k[m_alt], alt_k[0]);
            if (ns == 32) begin
               ns = 0;
               if (cfg_mode == 2'b10) fin = 1'b1;
            end
            if (na == 32) begin
               na = 0;
               fin = 1'b1;
            end
         end
         m_std <= ns;
         m_alt <= na;
         if (exit_cmd) m_en <= 1'b0;
         else if (fin) m_en <= 1'b1;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         n_vec++;
         if (cfg_en !== m_en) begin
            n_bad++;
            $display("FAIL %s cycle compare: cfg_en actual=%b expected=%b", cur_req, cfg_en, m_en);
         end
      end
   end

   task automatic expect_en(input bit e, input string r);
      #1;
      n_vec++;
      if (cfg_en !== e) begin
         n_bad++;
         $display("FAIL %s directed: cfg_en actual=%b expected=%b", r, cfg_en, e);
      end
   endtask

   // writes bytes [from..to] of a sequence, gap idle cycles after each
   task automatic send(input bit alt, input int from, input int to, input int gap);
      for (int i = from; i <= to; i++) begin
         @(negedge clk);
         wr_stb  = 1'b1;
         wr_data = alt ? alt_k[i] : std_k[i];
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            wr_stb = 1'b0;
         end
      end
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      wr_stb  = 1'b1;
      wr_data = b;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic do_exit();
      @(negedge clk);
      exit_cmd = 1'b1;
      @(negedge clk);
      exit_cmd = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: run incomplete actual=hung expected=finished");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      expect_en(1'b0, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      expect_en(1'b0, "R1");

      // R5: alternate sequence, jumper mode, back to back
      cur_req = "R5"; cfg_mode = 2'b00;
      send(1'b1, 0, 31, 0);
      expect_en(1'b1, "R5");
      cur_req = "R8";
      repeat (3) @(negedge clk);
      expect_en(1'b1, "R8");
      do_exit();
      expect_en(1'b0, "R8");

      // R6: standard sequence refused outside plug-and-play mode
      cur_req = "R6";
      cfg_mode = 2'b00; send(1'b0, 0, 31, 0); expect_en(1'b0, "R6");
      cfg_mode = 2'b01; send(1'b0, 0, 31, 0); expect_en(1'b0, "R6");
      cfg_mode = 2'b11; send(1'b0, 0, 31, 0); expect_en(1'b0, "R6");

      // R5 in jumperless and reserved modes
      cur_req = "R5";
      cfg_mode = 2'b01; send(1'b1, 0, 31, 0); expect_en(1'b1, "R5"); do_exit();
      cfg_mode = 2'b11; send(1'b1, 0, 31, 0); expect_en(1'b1, "R5"); do_exit();

      // R4 with R2: standard sequence in plug-and-play mode with idle gaps
      cur_req = "R4"; cfg_mode = 2'b10;
      send(1'b0, 0, 30, 2);
      expect_en(1'b0, "R2");
      send(1'b0, 31, 31, 0);
      expect_en(1'b1, "R4");
      do_exit();
      expect_en(1'b0, "R8");

      // R3: error midway, remainder written, then a full rewrite
      cur_req = "R3";
      send(1'b0, 0, 9, 0);
      send_byte(8'h00);
      send(1'b0, 10, 31, 0);
      expect_en(1'b0, "R3");
      send(1'b1, 0, 14, 0);
      send_byte(8'hFF);
      send(1'b1, 15, 31, 0);
      expect_en(1'b0, "R3");
      send(1'b0, 0, 31, 0);
      expect_en(1'b1, "R3");
      do_exit();

      // R7: repeated first byte restarts at position 1
      cur_req = "R7"; cfg_mode = 2'b01;
      send(1'b1, 0, 4, 0);
      send(1'b1, 0, 31, 0);
      expect_en(1'b1, "R7");
      do_exit();
      cfg_mode = 2'b10;
      send(1'b0, 0, 6, 1);
      send(1'b0, 0, 0, 0);
      send(1'b0, 1, 31, 0);
      expect_en(1'b1, "R7");
      do_exit();

      // R8: exit at the completing edge wins
      cur_req = "R8";
      send(1'b1, 0, 30, 0);
      @(negedge clk);
      wr_stb = 1'b1; wr_data = alt_k[31]; exit_cmd = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0; exit_cmd = 1'b0;
      expect_en(1'b0, "R8");

      // R1: reset mid-sequence drops progress
      cur_req = "R1";
      send(1'b1, 0, 19, 0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      send(1'b1, 20, 31, 0);
      expect_en(1'b0, "R1");

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule